// File: doc/BRIEF.md
# Level-Triggered DMA Request Sequencer

This block is a single-channel DMA sequencer started by an active-low level on a request input. A configuration write sets the source and destination start addresses, the number of beats in one block, the number of blocks, and how each address moves. The write can also arm the channel. While armed and idle, the sequencer samples the request input on every rising clock edge. A low level is held as a pending request, and the sequencer then asks for the bus.

Once the bus is granted, the sequencer spends one activation cycle clearing the pending request. It then runs one block. A block is a series of beats. In each beat the sequencer reads the source and, in the next cycle, writes the value it read to the destination. A dead cycle follows the block, and then the sequencer releases the bus.

Request acceptance stays closed from the moment a request is latched until the dead cycle is over. A low level seen in that window is dropped. When the last block finishes, the channel disarms itself and gives a one-cycle end pulse.

Top module: `dma_lvl_seq`

## Requirements
- R1: Sampling of `reqN` begins on the first rising edge after the edge that takes the arming configuration write. A `reqN` already low at that write raises `busReq` one cycle after the write.
- R2: A low `reqN` sampled while the channel is armed and idle is latched. From the next cycle, `busReq` is high and stays high until the dead cycle has ended. No bus access occurs while `busReq` is low.
- R3: After the grant is seen, one activation cycle follows before the first read. At least two cycles separate the cycle in which `busReq` rises from the first read. With `busGnt` held high, the first read comes exactly two cycles after `busReq` rises.
- R4: A beat is one read (`busValid`=1, `busWrite`=0) at the source address, followed in the next cycle by one write (`busValid`=1, `busWrite`=1) of that same read data to the destination address. A block has `cfgBlkSize` beats.
- R5: Each address increments by 1 after its own access when its increment flag is 1, and stays fixed when the flag is 0. At the end of a block, both addresses return to their configured start values if `cfgReload`=1, and otherwise continue from where they stopped. Addresses wrap modulo 2^ADDR_W.
- R6: After the last write of a block there is exactly one dead cycle, with `busReq`=1 and `busValid`=0. In the cycle after it, `busReq` is 0.
- R7: Acceptance is closed from the latching edge until the dead cycle ends. A low `reqN` in that window is ignored and not queued. A `reqN` that is low after acceptance reopens starts the next block.
- R8: When the final block's dead cycle ends, `xferEnd` is high for exactly one cycle (the cycle after the dead cycle) and the channel disarms. Any later low `reqN` raises no `busReq`.
- R9: An arming write with `cfgBlkSize`=0 or `cfgBlkCount`=0 leaves the channel disarmed, and no `busReq` follows.
- R10: The synchronous reset `rst` clears the pending request and the arm state and returns the sequencer to idle. In the first cycle after reset, `busReq`, `busValid` and `xferEnd` are 0, and a low `reqN` raises no `busReq` until the channel is armed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cfgWe | input | 1 | Configuration write strobe, taken only while idle |
| cfgEnable | input | 1 | Arm the channel with this write |
| cfgSrc | input | ADDR_W | Source start address |
| cfgDst | input | ADDR_W | Destination start address |
| cfgBlkSize | input | CNT_W | Beats per block |
| cfgBlkCount | input | CNT_W | Number of blocks |
| cfgSrcInc | input | 1 | Source address increments per beat |
| cfgDstInc | input | 1 | Destination address increments per beat |
| cfgReload | input | 1 | Reload both addresses at each block end |
| reqN | input | 1 | Level request, active low |
| busReq | output | 1 | Bus request, held from latch through the dead cycle |
| busGnt | input | 1 | Bus grant |
| busValid | output | 1 | Bus access this cycle |
| busWrite | output | 1 | Access is a write (else a read) |
| busAddr | output | ADDR_W | Access address |
| busWData | output | DATA_W | Write data |
| busRData | input | DATA_W | Read data, valid in the read cycle |
| xferEnd | output | 1 | One-cycle pulse when the last block finishes |

## Verification
The properties assume that `rst` is held for at least one clock edge before any check applies. They also assume that the read data bus answers in the same cycle as the read. They make no assumption about how long the grant takes, so they hold whether `busGnt` follows `busReq` after a delay or is tied high. The stimulus derives `busGnt` from `busReq` in exactly those two ways, and it issues configuration writes only while the sequencer is idle. This keeps every configuration change outside a running block.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REL,
    ST_ACT,
    ST_RD,
    ST_WR,
    ST_DEAD
  } seqState_t;

  typedef struct packed {
    logic cfgLoad;
    logic rdStep;
    logic wrStep;
    logic blkEnd;
    logic wrPhase;
  } seqStrobe_t;

endpackage

// File: rtl/dmaseq_addr.sv
module dmaseq_addr #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic          inc,
  input  logic          step,
  input  logic          blkEnd,
  input  logic          reload,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] baseR;
  logic          incR;

  always_ff @(posedge clk) begin
    if (rst) begin
      baseR <= '0;
      incR  <= 1'b0;
      addr  <= '0;
    end else if (load) begin
      baseR <= base;
      incR  <= inc;
      addr  <= base;
    end else if (blkEnd && reload) begin
      addr <= baseR;
    end else if (step && incR) begin
      addr <= addr + 1'b1;
    end
  end
endmodule

// File: rtl/dmaseq_ctrl.sv
module dmaseq_ctrl
  import dmaseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cfgWe,
  input  logic       cfgEnable,
  input  logic       cfgOk,
  input  logic       reqN,
  input  logic       busGnt,
  input  logic       lastBeat,
  input  logic       lastBlk,
  output seqStrobe_t strb,
  output logic       busReq,
  output logic       busValid,
  output logic       busWrite,
  output logic       xferEnd
);
  seqState_t st;
  logic      armed;
  logic      pending;
  logic      acceptOpen;

  assign acceptOpen = armed && (st == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      armed   <= 1'b0;
      pending <= 1'b0;
      xferEnd <= 1'b0;
    end else begin
      xferEnd <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (cfgWe) begin
            armed <= cfgEnable && cfgOk;
          end else if (acceptOpen && !reqN) begin
            pending <= 1'b1;
            st      <= ST_REL;
          end
        end
        ST_REL:  if (busGnt) st <= ST_ACT;
        ST_ACT: begin
          pending <= 1'b0;
          st      <= ST_RD;
        end
        ST_RD:   st <= ST_WR;
        ST_WR:   st <= lastBeat ? ST_DEAD : ST_RD;
        ST_DEAD: begin
          st <= ST_IDLE;
          if (lastBlk) begin
            armed   <= 1'b0;
            xferEnd <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.cfgLoad = (st == ST_IDLE) && cfgWe;
    strb.rdStep  = (st == ST_RD);
    strb.wrStep  = (st == ST_WR);
    strb.blkEnd  = (st == ST_DEAD);
    strb.wrPhase = (st == ST_WR);
  end

  assign busValid = (st == ST_RD) || (st == ST_WR);
  assign busWrite = (st == ST_WR);
  assign busReq   = pending || busValid || (st == ST_DEAD);
endmodule

// File: rtl/dmaseq_dpath.sv
module dmaseq_dpath
  import dmaseq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  seqStrobe_t    strb,
  input  logic [AW-1:0] cfgSrc,
  input  logic [AW-1:0] cfgDst,
  input  logic [CW-1:0] cfgBlkSize,
  input  logic [CW-1:0] cfgBlkCount,
  input  logic          cfgSrcInc,
  input  logic          cfgDstInc,
  input  logic          cfgReload,
  input  logic [DW-1:0] busRData,
  output logic [AW-1:0] busAddr,
  output logic [DW-1:0] busWData,
  output logic          lastBeat,
  output logic          lastBlk,
  output logic          cfgOk
);
  localparam int SIDES = 2;

  logic [CW-1:0] sizeR;
  logic [CW-1:0] beatLeft;
  logic [CW-1:0] blkLeft;
  logic          reloadR;
  logic [DW-1:0] dataR;

  logic [SIDES-1:0][AW-1:0] sideBase;
  logic [SIDES-1:0][AW-1:0] sideAddr;
  logic [SIDES-1:0]         sideInc;
  logic [SIDES-1:0]         sideStep;

  assign sideBase = {cfgDst, cfgSrc};
  assign sideInc  = {cfgDstInc, cfgSrcInc};
  assign sideStep = {strb.wrStep, strb.rdStep};

  for (genvar g = 0; g < SIDES; g++) begin : g_side
    dmaseq_addr #(.AW(AW)) u_addr (
      .clk    (clk),
      .rst    (rst),
      .load   (strb.cfgLoad),
      .base   (sideBase[g]),
      .inc    (sideInc[g]),
      .step   (sideStep[g]),
      .blkEnd (strb.blkEnd),
      .reload (reloadR),
      .addr   (sideAddr[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sizeR    <= '0;
      beatLeft <= '0;
      blkLeft  <= '0;
      reloadR  <= 1'b0;
      dataR    <= '0;
    end else begin
      if (strb.cfgLoad) begin
        sizeR    <= cfgBlkSize;
        beatLeft <= cfgBlkSize;
        blkLeft  <= cfgBlkCount;
        reloadR  <= cfgReload;
      end
      if (strb.rdStep) dataR <= busRData;
      if (strb.wrStep) beatLeft <= beatLeft - 1'b1;
      if (strb.blkEnd) begin
        beatLeft <= sizeR;
        blkLeft  <= blkLeft - 1'b1;
      end
    end
  end

  assign busAddr  = strb.wrPhase ? sideAddr[1] : sideAddr[0];
  assign busWData = dataR;
  assign lastBeat = (beatLeft == CW'(1));
  assign lastBlk  = (blkLeft == CW'(1));
  assign cfgOk    = (|cfgBlkSize) && (|cfgBlkCount);
endmodule

// File: rtl/dma_lvl_seq.sv
module dma_lvl_seq
  import dmaseq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfgWe,
  input  logic              cfgEnable,
  input  logic [ADDR_W-1:0] cfgSrc,
  input  logic [ADDR_W-1:0] cfgDst,
  input  logic [CNT_W-1:0]  cfgBlkSize,
  input  logic [CNT_W-1:0]  cfgBlkCount,
  input  logic              cfgSrcInc,
  input  logic              cfgDstInc,
  input  logic              cfgReload,
  input  logic              reqN,
  output logic              busReq,
  input  logic              busGnt,
  output logic              busValid,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWData,
  input  logic [DATA_W-1:0] busRData,
  output logic              xferEnd
);
  seqStrobe_t strb;
  logic       lastBeat;
  logic       lastBlk;
  logic       cfgOk;

  dmaseq_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cfgWe     (cfgWe),
    .cfgEnable (cfgEnable),
    .cfgOk     (cfgOk),
    .reqN      (reqN),
    .busGnt    (busGnt),
    .lastBeat  (lastBeat),
    .lastBlk   (lastBlk),
    .strb      (strb),
    .busReq    (busReq),
    .busValid  (busValid),
    .busWrite  (busWrite),
    .xferEnd   (xferEnd)
  );

  dmaseq_dpath #(.AW(ADDR_W), .DW(DATA_W), .CW(CNT_W)) u_dpath (
    .clk         (clk),
    .rst         (rst),
    .strb        (strb),
    .cfgSrc      (cfgSrc),
    .cfgDst      (cfgDst),
    .cfgBlkSize  (cfgBlkSize),
    .cfgBlkCount (cfgBlkCount),
    .cfgSrcInc   (cfgSrcInc),
    .cfgDstInc   (cfgDstInc),
    .cfgReload   (cfgReload),
    .busRData    (busRData),
    .busAddr     (busAddr),
    .busWData    (busWData),
    .lastBeat    (lastBeat),
    .lastBlk     (lastBlk),
    .cfgOk       (cfgOk)
  );
endmodule

// File: rtl/dmaseq_chk.sv
module dmaseq_chk (
  input logic clk,
  input logic rst,
  input logic busReq,
  input logic busValid,
  input logic busWrite,
  input logic xferEnd
);
  // R2: no bus access without an outstanding request
  p_access_needs_req_r2: assert property (@(posedge clk) disable iff (rst)
    busValid |-> busReq);

  // R3: two quiet cycles between latch and first read
  p_gap_after_latch_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(busReq) |-> !busValid ##1 !busValid);

  // R4: each read is followed by a write
  p_write_follows_read_r4: assert property (@(posedge clk) disable iff (rst)
    (busValid && !busWrite) |=> (busValid && busWrite));

  // R6: the dead cycle is single and ends with release
  p_dead_then_release_r6: assert property (@(posedge clk) disable iff (rst)
    (busReq && !busValid && $past(busWrite)) |=> !busReq);

  // R8: end pulse lasts one cycle and nothing restarts
  p_end_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    xferEnd |-> !busReq ##1 (!xferEnd && !busReq));

  // R10: quiet right after reset
  p_reset_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busReq && !busValid && !xferEnd));
endmodule

bind dma_lvl_seq dmaseq_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .busReq   (busReq),
  .busValid (busValid),
  .busWrite (busWrite),
  .xferEnd  (xferEnd)
);

// File: tb/dma_lvl_seq_bench.sv
module dma_lvl_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam logic [15:0] KEY = 16'hA5C3;

  typedef struct packed {
    logic [15:0] src;
    logic [15:0] dst;
    logic [7:0]  size;
    logic [7:0]  cnt;
    logic        sInc;
    logic        dInc;
    logic        rl;
  } vec_t;

  localparam int NVEC = 4;
  localparam vec_t VECS [NVEC] = '{
    '{16'h1000, 16'h2000, 8'd3, 8'd2, 1'b1, 1'b1, 1'b0},
    '{16'h0100, 16'h0800, 8'd2, 8'd3, 1'b1, 1'b0, 1'b1},
    '{16'h4000, 16'h5000, 8'd1, 8'd4, 1'b0, 1'b1, 1'b0},
    '{16'hFFFE, 16'h0003, 8'd4, 8'd1, 1'b1, 1'b1, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfgWe = 1'b0, cfgEnable = 1'b0;
  logic [15:0] cfgSrc = '0, cfgDst = '0;
  logic [7:0]  cfgBlkSize = '0, cfgBlkCount = '0;
  logic        cfgSrcInc = 1'b0, cfgDstInc = 1'b0, cfgReload = 1'b0;
  logic        reqN = 1'b1;
  logic        busReq, busValid, busWrite, xferEnd;
  logic        busGnt, gntDly, gntForce = 1'b0;
  logic [15:0] busAddr, busWData, busRData;

  int total = 0;
  int fails = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  always_ff @(posedge clk) begin
    if (rst) gntDly <= 1'b0;
    else     gntDly <= busReq;
  end
  assign busGnt   = gntForce | gntDly;
  assign busRData = busAddr ^ KEY;

  dma_lvl_seq u_dma_lvl_seq (
    .clk(clk), .rst(rst), .cfgWe(cfgWe), .cfgEnable(cfgEnable),
    .cfgSrc(cfgSrc), .cfgDst(cfgDst), .cfgBlkSize(cfgBlkSize),
    .cfgBlkCount(cfgBlkCount), .cfgSrcInc(cfgSrcInc), .cfgDstInc(cfgDstInc),
    .cfgReload(cfgReload), .reqN(reqN), .busReq(busReq), .busGnt(busGnt),
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .busWData(busWData), .busRData(busRData), .xferEnd(xferEnd)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cfgWrite(input vec_t v, input logic en);
    cfgSrc = v.src; cfgDst = v.dst; cfgBlkSize = v.size; cfgBlkCount = v.cnt;
    cfgSrcInc = v.sInc; cfgDstInc = v.dInc; cfgReload = v.rl;
    cfgEnable = en; cfgWe = 1'b1;
    tick();
    cfgWe = 1'b0;
  endtask

  task automatic quietFor(input int n, input string req);
    bit seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (busReq) seen = 1'b1;
      tick();
    end
    chk(!seen, req, "busReq stayed low", int'(seen), 0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    vec_t v;
    @(negedge clk);
    repeat (3) tick();
    rst = 1'b0;
    // R10: reset state
    chk(!busReq && !busValid && !xferEnd, "R10", "outputs after reset",
        {busReq, busValid, xferEnd}, 0);

    // R1 R3 R6 R8: exact timing with grant held high
    gntForce = 1'b1;
    reqN = 1'b0;
    cfgWrite('{16'h0040, 16'h0080, 8'd1, 8'd1, 1'b1, 1'b1, 1'b0}, 1'b1);
    chk(!busReq, "R1", "no latch on write edge", busReq, 0);
    tick();
    chk(busReq, "R1", "latch on next edge", busReq, 1);
    tick();
    chk(!busValid, "R3", "activation cycle quiet", busValid, 0);
    tick();
    chk(busValid && !busWrite && busAddr == 16'h0040, "R3", "read two cycles after latch",
        {busValid, busWrite, busAddr}, {1'b1, 1'b0, 16'h0040});
    tick();
    chk(busValid && busWrite && busWData == (16'h0040 ^ KEY), "R4", "write of read data",
        busWData, 16'h0040 ^ KEY);
    tick();
    chk(busReq && !busValid, "R6", "dead cycle", {busReq, busValid}, 2'b10);
    tick();
    chk(!busReq && xferEnd, "R6", "release and end pulse", {busReq, xferEnd}, 2'b01);
    tick();
    chk(!xferEnd, "R8", "end pulse one cycle", xferEnd, 0);
    quietFor(6, "R8");
    reqN = 1'b1;
    gntForce = 1'b0;
    tick();

    // R4 R5 R8: vector table walk with delayed grant
    for (int k = 0; k < NVEC; k++) begin
      logic [15:0] eSrc, eDst, lastRd;
      int nRd, nEnd, beat;
      bit done;
      v = VECS[k];
      eSrc = v.src; eDst = v.dst; lastRd = '0;
      nRd = 0; nEnd = 0; beat = 0; done = 1'b0;
      reqN = 1'b0;
      cfgWrite(v, 1'b1);
      for (int c = 0; c < 400 && !done; c++) begin
        if (busValid && !busWrite) begin
          chk(busAddr == eSrc, "R5", "read address", busAddr, eSrc);
          lastRd = eSrc;
          if (v.sInc) eSrc = eSrc + 16'd1;
          nRd++;
        end
        if (busValid && busWrite) begin
          chk(busAddr == eDst, "R5", "write address", busAddr, eDst);
          chk(busWData == (lastRd ^ KEY), "R4", "write data", busWData, lastRd ^ KEY);
          if (v.dInc) eDst = eDst + 16'd1;
          beat++;
          if (beat == int'(v.size)) begin
            beat = 0;
            if (v.rl) begin eSrc = v.src; eDst = v.dst; end
          end
        end
        if (xferEnd) begin nEnd++; done = 1'b1; end
        tick();
      end
      chk(nRd == int'(v.size) * int'(v.cnt), "R4", "beats in transfer", nRd,
          int'(v.size) * int'(v.cnt));
      chk(nEnd == 1, "R8", "end pulse seen", nEnd, 1);
      quietFor(5, "R8");
      reqN = 1'b1;
      tick();
    end

    // R7: low during a block is ignored
    reqN = 1'b0;
    cfgWrite('{16'h0200, 16'h0300, 8'd2, 8'd2, 1'b1, 1'b1, 1'b0}, 1'b1);
    tick();
    chk(busReq, "R2", "request latched", busReq, 1);
    reqN = 1'b1;
    for (int i = 0; i < 10 && !busValid; i++) tick();
    reqN = 1'b0;
    tick();
    reqN = 1'b1;
    for (int i = 0; i < 20 && busReq; i++) tick();
    quietFor(8, "R7");
    reqN = 1'b0;
    tick();
    chk(busReq, "R7", "reopened acceptance latches", busReq, 1);
    begin
      bit endSeen = 1'b0;
      for (int i = 0; i < 30 && !endSeen; i++) begin
        if (xferEnd) endSeen = 1'b1;
        tick();
      end
      chk(endSeen, "R8", "second block ends transfer", int'(endSeen), 1);
    end
    reqN = 1'b1;
    tick();

    // R9: zero size or count stays disarmed
    reqN = 1'b0;
    cfgWrite('{16'h0010, 16'h0020, 8'd0, 8'd2, 1'b1, 1'b1, 1'b0}, 1'b1);
    quietFor(6, "R9");
    cfgWrite('{16'h0010, 16'h0020, 8'd2, 8'd0, 1'b1, 1'b1, 1'b0}, 1'b1);
    quietFor(6, "R9");
    reqN = 1'b1;
    tick();

    // R10: reset in the middle of a block
    reqN = 1'b0;
    cfgWrite('{16'h0600, 16'h0700, 8'd4, 8'd3, 1'b1, 1'b1, 1'b0}, 1'b1);
    for (int i = 0; i < 10 && !busValid; i++) tick();
    chk(busValid, "R10", "block running before reset", busValid, 1);
    rst = 1'b1;
    tick();
    tick();
    rst = 1'b0;
    chk(!busReq && !busValid && !xferEnd, "R10", "idle after reset",
        {busReq, busValid, xferEnd}, 0);
    quietFor(6, "R10");
    reqN = 1'b1;

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule